// File: doc/BRIEF.md
# Display Output Timing Error Monitor

This block watches one display channel at the point where a line compositor feeds its output FIFO. It tracks how many pixels of the current output line are still owed to the downstream timing generator. It also counts completed lines within the frame, watches FIFO reads against the empty flag, and follows the channel's run mode. From these it raises one-cycle event pulses that an interrupt register block can latch.

A sync strobe that arrives while pixels of the current line are still owed points to a geometry mismatch between the compositor and the timing generator. The block reports this as a short line or a short frame. It also reports FIFO underflow, the end of each frame, and the completion of one programmable line per frame.

Top module: `disp_err_mon`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, all five event outputs are 0. The pixel counter and the line index are both 0.
- R2: When `line_start_i` is 1, `frame_start_i` is 0 and the pixel counter is nonzero, `short_line_o` is 1 for exactly the following cycle. A line start with the counter at zero gives no pulse.
- R3: When `frame_start_i` is 1 and the pixel counter is nonzero, `short_frame_o` is 1 for the following cycle. `short_line_o` stays 0 in that cycle, even if `line_start_i` is also 1. A frame start with the counter at zero gives no pulse.
- R4: `underflow_o` is 1 in the cycle after one where `fifo_rd_i` and `fifo_empty_i` are both 1. A read from a non-empty FIFO gives no pulse, and neither does an empty FIFO that is not read.
- R5: `end_of_frame_o` is 1 for one cycle after `mode_run_i` goes from 1 (run) to 0 (end of frame). It stays 0 on a 0-to-1 change and while the mode holds steady.
- R6: On either strobe, the pixel counter loads `line_width_i`. It drops by one on each cycle with `pix_accept_i` high and no strobe. A `pix_accept_i` while the counter is zero has no effect.
- R7: After a short line or a short frame, the remaining pixels of the abandoned line are dropped. Exactly `line_width_i` accepted pixels are then needed before a line start is free of error.
- R8: A line completes when its last owed pixel is accepted. Lines are numbered from 0 at frame start, and only completed lines advance the number, so an abandoned short line does not. `end_of_line_n_o` is 1 in the cycle after the completion of line number `eoln_line_i`.
- R9: `frame_start_i` resets the line number to 0. `end_of_line_n_o` fires at most once between two frame starts, even if `eoln_line_i` is changed after it has fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_width_i | input | WIDTH_W | Pixels per output line |
| eoln_line_i | input | LINE_W | Line number that raises the end-of-line-N event |
| frame_start_i | input | 1 | Frame-start strobe from the timing generator |
| line_start_i | input | 1 | Line-start strobe from the timing generator |
| pix_accept_i | input | 1 | One pixel of the current line delivered |
| fifo_rd_i | input | 1 | Downstream read of the display FIFO |
| fifo_empty_i | input | 1 | Display FIFO empty flag |
| mode_run_i | input | 1 | Channel mode: 1 run, 0 end of frame |
| short_frame_o | output | 1 | Short-frame event pulse |
| short_line_o | output | 1 | Short-line event pulse |
| underflow_o | output | 1 | FIFO underflow event pulse |
| end_of_frame_o | output | 1 | End-of-frame event pulse |
| end_of_line_n_o | output | 1 | Programmed line completed pulse |

## Verification
Every event output is one register stage after its cause, so each result is due in the cycle directly after the edge that samples the stimulus. The counter and line-index updates take effect at that same edge. The bench applies each stimulus at a falling edge and checks the outputs just after the next rising edge. It then checks again one cycle later to confirm that a pulse has dropped. Multi-pixel scenarios are driven one pixel per cycle, and the programmed-line output is checked after every pixel so that an early or late pulse is caught.

// File: rtl/disp_err_mon.sv
module disp_err_mon #(
  parameter int WIDTH_W = 12,
  parameter int LINE_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] line_width_i,
  input  logic [LINE_W-1:0]  eoln_line_i,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               pix_accept_i,
  input  logic               fifo_rd_i,
  input  logic               fifo_empty_i,
  input  logic               mode_run_i,
  output logic               short_frame_o,
  output logic               short_line_o,
  output logic               underflow_o,
  output logic               end_of_frame_o,
  output logic               end_of_line_n_o
);

  logic [WIDTH_W-1:0] pix_left;
  logic [LINE_W-1:0]  line_idx;
  logic               eoln_done;
  logic               run_q;

  wire strobe    = frame_start_i | line_start_i;
  wire pending   = pix_left != '0;
  wire line_done = !strobe && pix_accept_i && (pix_left == WIDTH_W'(1));
  wire hit       = line_done && !eoln_done && (line_idx == eoln_line_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_left        <= '0;
      line_idx        <= '0;
      eoln_done       <= 1'b0;
      run_q           <= 1'b0;
      short_frame_o   <= 1'b0;
      short_line_o    <= 1'b0;
      underflow_o     <= 1'b0;
      end_of_frame_o  <= 1'b0;
      end_of_line_n_o <= 1'b0;
    end else begin
      short_frame_o   <= frame_start_i && pending;
      short_line_o    <= line_start_i && !frame_start_i && pending;
      underflow_o     <= fifo_rd_i && fifo_empty_i;
      run_q           <= mode_run_i;
      end_of_frame_o  <= run_q && !mode_run_i;
      end_of_line_n_o <= hit;

      if (strobe)
        pix_left <= line_width_i;
      else if (pix_accept_i && pending)
        pix_left <= pix_left - WIDTH_W'(1);

      if (frame_start_i) begin
        line_idx  <= '0;
        eoln_done <= 1'b0;
      end else if (line_done) begin
        line_idx <= line_idx + LINE_W'(1);
        if (hit) eoln_done <= 1'b1;
      end
    end
  end

  AST_SHORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_frame_o && short_line_o));                                    // R3
  AST_SHORT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && !frame_start_i && pending) |=> short_line_o);        // R2
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_i && fifo_empty_i) |=> underflow_o);                        // R4
  AST_EOF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_run_i) |=> end_of_frame_o);                               // R5
  AST_PIX_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && pix_accept_i && !strobe) |=> (pix_left == $past(pix_left) - WIDTH_W'(1))); // R6
  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (pix_left == $past(line_width_i)));                       // R7
  AST_EOLN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_of_line_n_o && !frame_start_i) |=> !end_of_line_n_o);           // R9

endmodule

// File: tb/test_disp_err_mon.sv
module test_disp_err_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] line_width = 12'd0;
  logic [11:0] eoln_line = 12'd0;
  logic        fs = 1'b0, ls = 1'b0, pa = 1'b0, rd = 1'b0, emp = 1'b0, run = 1'b0;
  logic        sf, sl, uf, eof, eoln;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  disp_err_mon #(.WIDTH_W(12), .LINE_W(12)) i_disp_err_mon (
    .clk(clk), .rst_n(rst_n), .line_width_i(line_width), .eoln_line_i(eoln_line),
    .frame_start_i(fs), .line_start_i(ls), .pix_accept_i(pa),
    .fifo_rd_i(rd), .fifo_empty_i(emp), .mode_run_i(run),
    .short_frame_o(sf), .short_line_o(sl), .underflow_o(uf),
    .end_of_frame_o(eof), .end_of_line_n_o(eoln));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic l, input logic p, input logic r, input logic e);
    @(negedge clk);
    fs = f; ls = l; pa = p; rd = r; emp = e;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sf in reset", sf, 1'b0);
    chk("R1", "eoln in reset", eoln, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "outputs after reset", sf | sl | uf | eof | eoln, 1'b0);
    step(0, 1, 0, 0, 0);
    chk("R1", "counter zero: no short line", sl, 1'b0);
  endtask

  task automatic t_short_line();
    line_width = 12'd4;
    step(1, 0, 0, 0, 0);
    chk("R3", "frame start with empty counter", sf, 1'b0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R2", "short line pulse", sl, 1'b1);
    chk("R2", "no short frame", sf, 1'b0);
    idle();
    chk("R2", "short line one cycle", sl, 1'b0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R7", "restart needs full width", sl, 1'b1);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R6", "extra pixels at zero ignored", sl, 1'b0);
  endtask

  task automatic t_short_frame();
    line_width = 12'd4;
    step(0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R3", "short frame pulse", sf, 1'b1);
    chk("R3", "short line suppressed", sl, 1'b0);
    step(0, 0, 1, 0, 0);
    chk("R3", "short frame one cycle", sf, 1'b0);
    step(1, 1, 0, 0, 0);
    chk("R3", "both strobes: short frame", sf, 1'b1);
    chk("R3", "both strobes: no short line", sl, 1'b0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R7", "complete line then frame start", sf, 1'b0);
  endtask

  task automatic t_underflow();
    step(0, 0, 0, 1, 1);
    chk("R4", "read while empty", uf, 1'b1);
    step(0, 0, 0, 1, 0);
    chk("R4", "read not empty", uf, 1'b0);
    step(0, 0, 0, 0, 1);
    chk("R4", "empty not read", uf, 1'b0);
  endtask

  task automatic t_eof();
    @(negedge clk); run = 1'b1;
    @(posedge clk); #1;
    chk("R5", "rise no pulse", eof, 1'b0);
    idle();
    chk("R5", "steady run", eof, 1'b0);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    chk("R5", "run to eof pulse", eof, 1'b1);
    idle();
    chk("R5", "pulse one cycle", eof, 1'b0);
  endtask

  task automatic t_eoln();
    line_width = 12'd3;
    eoln_line = 12'd2;
    step(1, 0, 0, 0, 0);
    for (int ln = 0; ln < 4; ln++) begin
      if (ln > 0) step(0, 1, 0, 0, 0);
      for (int p = 0; p < 3; p++) begin
        step(0, 0, 1, 0, 0);
        chk("R8", $sformatf("line %0d pixel %0d", ln, p), eoln, (ln == 2 && p == 2));
      end
      if (ln == 2) eoln_line = 12'd3;
    end
    chk("R9", "no second pulse in frame", eoln, 1'b0);
    eoln_line = 12'd0;
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R8", "abandoned line short", sl, 1'b1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R8", "not yet complete", eoln, 1'b0);
    step(0, 0, 1, 0, 0);
    chk("R9", "line 0 after new frame", eoln, 1'b1);
    idle();
    chk("R8", "eoln one cycle", eoln, 1'b0);
  endtask

  initial begin
    t_reset();
    t_short_line();
    t_short_frame();
    t_underflow();
    t_eof();
    t_eoln();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule